// File: doc/BRIEF.md
# MAC Interrupt Event and Mask Unit

This unit collects single-cycle event pulses from the surrounding MAC datapath into a sticky 32-bit event register. Software reads the register, and writes ones to acknowledge the bits it has handled. A second 32-bit register holds interrupt enables. For each maskable event, its enable bit sits exactly sixteen positions above the event bit. The unit compares the event register with the enables, shifted down by sixteen, and drives two level interrupt lines. The error line covers the three memory-ECC events (timestamp FIFO, transmit frame, receive frame). The normal line covers magic-packet detection.

Software reaches both registers through a single-word port: a write strobe, one address bit, write data and combinational read data. The asynchronous reset input is released through an internal two-stage synchronizer. The event register and the mask register both come out of reset empty. After reset, software normally writes the four enables.

Top module: `irq_evt_unit`

## Requirements
- R1: After reset, the event register, the mask register and both interrupt outputs read zero.
- R2: A one on `hw_evt` for an implemented bit sets that event bit at the next clock edge. The bit then stays set until software clears it. The implemented bits are 31, 30, 29, 14 down to 4, and 2, 1, 0.
- R3: A write with `reg_addr`=0 clears every event bit where `reg_wdata` is one and leaves the bits where it is zero unchanged. Writing all ones clears the whole register.
- R4: A set pulse and a software clear on the same bit in the same cycle leave that bit set.
- R5: Bits 3 and 15 to 28 of the event register are never set, whatever arrives on `hw_evt`.
- R6: A write with `reg_addr`=1 loads all 32 bits of the mask register, and `reg_rdata` returns them unchanged.
- R7: `err_irq` is registered. It is high in the cycle after the registers hold at least one of these pairs: event bit 13 with mask bit 29, event bit 9 with mask bit 25, or event bit 8 with mask bit 24. Otherwise it is low.
- R8: `norm_irq` is registered. It is high in the cycle after the registers hold event bit 14 together with mask bit 30. Otherwise it is low.
- R9: A set event whose enable is clear does not raise either line. An event outside the two classes does not raise either line, even when the mask bit sixteen above it is set (for example event bit 12 with mask bit 28).
- R10: Reading either register has no side effect. `reg_rdata` shows the event register when `reg_addr`=0 and the mask register when `reg_addr`=1, with the state as it stands in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hw_evt | input | 32 | Single-cycle event pulses, one per event bit |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 event, 1 mask |
| reg_wdata | input | 32 | Write data (clear pattern or mask value) |
| reg_rdata | output | 32 | Read data for the selected register |
| err_irq | output | 1 | Error-class interrupt level |
| norm_irq | output | 1 | Normal-class interrupt level |

## Verification
The bench builds the unit with its default parameters: a 32-bit register width, a mask offset of sixteen, and the implemented-bit, error-class and normal-class patterns listed above. With these values, the bench can reach every real event position, including each unimplemented gap bit. It can also reach a non-class event whose shifted enable is set, and a set pulse that collides with a clear on the same bit. A behavioural model compares the read data and both interrupt lines on every cycle, covering the one-cycle lag of the lines behind the registers.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;

  localparam int unsigned REG_W = 32;

  // register select on the one-bit address
  typedef enum logic {
    SEL_EVENT = 1'b0,
    SEL_MASK  = 1'b1
  } reg_sel_e;

  // default bit patterns
  localparam logic [REG_W-1:0] IMPL_DFLT = 32'hE000_7FF7;
  localparam logic [REG_W-1:0] ERR_DFLT  = 32'h0000_2300;
  localparam logic [REG_W-1:0] NORM_DFLT = 32'h0000_4000;
  localparam int unsigned      SHIFT_DFLT = 16;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/irq_evt_bank.sv
module irq_evt_bank #(
  parameter int unsigned      W    = 32,
  parameter logic [W-1:0]     IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_pulse,
  input  logic         clr_en,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] evt_q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    if (IMPL[b]) begin : g_live
      logic bit_q, bit_d, bit_en;
      always_comb begin
        // set wins over a clear in the same cycle
        bit_en = set_pulse[b] | (clr_en & clr_bits[b]);
        bit_d  = set_pulse[b];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bit_q <= 1'b0;
        else if (bit_en) bit_q <= bit_d;
      end
      assign evt_q[b] = bit_q;
    end else begin : g_tied
      assign evt_q[b] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] mask_q
);
  logic [W-1:0] mask_d;

  always_comb begin
    mask_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask_q <= '0;
    else if (wr_en) mask_q <= mask_d;
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int unsigned  W     = 32,
  parameter int unsigned  SHIFT = 16,
  parameter logic [W-1:0] ERR   = '0,
  parameter logic [W-1:0] NORM  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] mask,
  output logic         err_irq,
  output logic         norm_irq
);
  logic [W-1:0] pend;
  logic         err_d, norm_d;

  always_comb begin
    pend   = evt & (mask >> SHIFT);
    err_d  = |(pend & ERR);
    norm_d = |(pend & NORM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_irq  <= 1'b0;
      norm_irq <= 1'b0;
    end else begin
      err_irq  <= err_d;
      norm_irq <= norm_d;
    end
  end
endmodule

// File: rtl/irq_evt_unit.sv
module irq_evt_unit
  import irq_evt_pkg::*;
#(
  parameter int unsigned          DATA_W     = REG_W,
  parameter int unsigned          MASK_SHIFT = SHIFT_DFLT,
  parameter logic [DATA_W-1:0]    EVT_IMPL   = IMPL_DFLT,
  parameter logic [DATA_W-1:0]    ERR_CLASS  = ERR_DFLT,
  parameter logic [DATA_W-1:0]    NORM_CLASS = NORM_DFLT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] hw_evt,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              err_irq,
  output logic              norm_irq
);
  logic              rst_n_s;
  logic [DATA_W-1:0] evt_q;
  logic [DATA_W-1:0] mask_q;
  logic              evt_wr, mask_wr;
  reg_sel_e          sel;

  always_comb begin
    sel     = reg_sel_e'(reg_addr);
    evt_wr  = reg_we && (sel == SEL_EVENT);
    mask_wr = reg_we && (sel == SEL_MASK);
  end

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  irq_evt_bank #(.W(DATA_W), .IMPL(EVT_IMPL)) u_evt (
    .clk(clk), .rst_n(rst_n_s), .set_pulse(hw_evt),
    .clr_en(evt_wr), .clr_bits(reg_wdata), .evt_q(evt_q)
  );

  irq_mask_reg #(.W(DATA_W)) u_mask (
    .clk(clk), .rst_n(rst_n_s), .wr_en(mask_wr),
    .wr_data(reg_wdata), .mask_q(mask_q)
  );

  irq_gate #(.W(DATA_W), .SHIFT(MASK_SHIFT), .ERR(ERR_CLASS), .NORM(NORM_CLASS)) u_gate (
    .clk(clk), .rst_n(rst_n_s), .evt(evt_q), .mask(mask_q),
    .err_irq(err_irq), .norm_irq(norm_irq)
  );

  always_comb begin
    reg_rdata = (sel == SEL_MASK) ? mask_q : evt_q;
  end
endmodule

// File: rtl/irq_evt_chk.sv
module irq_evt_chk #(
  parameter int unsigned       DATA_W     = 32,
  parameter int unsigned       MASK_SHIFT = 16,
  parameter logic [DATA_W-1:0] EVT_IMPL   = '1,
  parameter logic [DATA_W-1:0] ERR_CLASS  = '0,
  parameter logic [DATA_W-1:0] NORM_CLASS = '0
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic [DATA_W-1:0] hw_evt,
  input logic              reg_we,
  input logic              reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] evt_q,
  input logic [DATA_W-1:0] mask_q,
  input logic              err_irq,
  input logic              norm_irq
);
  // R2 / R4: a pulse on an implemented bit is present next cycle, clear or not
  p_pulse_sets_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    1'b1 |=> ((evt_q & $past(hw_evt & EVT_IMPL)) == $past(hw_evt & EVT_IMPL)));

  // R2: without an event write, no set bit is lost
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(reg_we && !reg_addr) |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

  // R3: a clear with no coincident pulse drops the written bits
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_we && !reg_addr && hw_evt == '0) |=> ((evt_q & $past(reg_wdata)) == '0));

  // R5: gap bits never read as set
  p_gap_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_addr == 1'b0) |-> ((evt_q & ~EVT_IMPL) == '0));

  // R6: mask write lands in full
  p_mask_load_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_we && reg_addr) |=> (mask_q == $past(reg_wdata)));

  // R7: error line follows the masked error events one cycle later
  p_err_line_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    1'b1 |=> (err_irq == $past(|(evt_q & (mask_q >> MASK_SHIFT) & ERR_CLASS))));

  // R8: normal line follows the masked magic-packet event one cycle later
  p_norm_line_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    1'b1 |=> (norm_irq == $past(|(evt_q & (mask_q >> MASK_SHIFT) & NORM_CLASS))));
endmodule

bind irq_evt_unit irq_evt_chk #(
  .DATA_W(DATA_W), .MASK_SHIFT(MASK_SHIFT), .EVT_IMPL(EVT_IMPL),
  .ERR_CLASS(ERR_CLASS), .NORM_CLASS(NORM_CLASS)
) u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .hw_evt(hw_evt), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .evt_q(evt_q),
  .mask_q(mask_q), .err_irq(err_irq), .norm_irq(norm_irq)
);

// File: tb/tb_irq_evt_unit.sv
module tb_irq_evt_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] hw_evt;
  logic        reg_we;
  logic        reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        err_irq, norm_irq;

  int vectors = 0;
  int errors  = 0;

  // reference state
  logic [31:0] m_evt, m_mask;
  logic        m_err, m_norm;
  localparam logic [31:0] IMPL = 32'hE000_7FF7;

  always #10 clk = ~clk;  // 50 MHz

  irq_evt_unit dut (
    .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .err_irq(err_irq), .norm_irq(norm_irq)
  );

  task automatic compare(input string tag);
    logic [31:0] exp_rd;
    exp_rd = reg_addr ? m_mask : m_evt;
    vectors++;
    if (reg_rdata !== exp_rd || err_irq !== m_err || norm_irq !== m_norm) begin
      errors++;
      $display("FAIL %s: rdata=%h err=%b norm=%b expected rdata=%h err=%b norm=%b",
               tag, reg_rdata, err_irq, norm_irq, exp_rd, m_err, m_norm);
    end
  endtask

  // one clock: apply inputs, advance the model at the edge, check at the falling edge
  task automatic step(input logic [31:0] ev, input logic we, input logic ad,
                      input logic [31:0] wd, input string tag);
    logic [31:0] pend;
    hw_evt = ev; reg_we = we; reg_addr = ad; reg_wdata = wd;
    @(posedge clk);
    pend   = m_evt & (m_mask >> 16);
    m_err  = (pend[13] || pend[9] || pend[8]);
    m_norm = pend[14];
    if (we && !ad) m_evt = m_evt & ~wd;
    m_evt = m_evt | (ev & IMPL);
    if (we && ad) m_mask = wd;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input int n, input logic ad, input string tag);
    for (int i = 0; i < n; i++) step(32'h0, 1'b0, ad, 32'h0, tag);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hw_evt = '0; reg_we = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    m_evt = '0; m_mask = '0; m_err = 1'b0; m_norm = 1'b0;
    repeat (3) @(negedge clk);
    compare("R1 event in reset");
    reg_addr = 1'b1; #1; compare("R1 mask in reset");
    rst_n = 1'b1;
    idle(3, 1'b0, "R1 event after release");
    idle(2, 1'b1, "R1 mask after release");

    // R2: pulses latch and stay
    step(32'h0000_2001, 1'b0, 1'b0, 32'h0, "R2 set bits 13,0");
    idle(3, 1'b0, "R2 sticky");

    // R6: mask load with ECC, magic and bit 28 enables
    step(32'h0, 1'b1, 1'b1, 32'h7300_0000, "R6 mask write");
    idle(1, 1'b1, "R6 mask readback");
    // R7: error line rises one cycle after registers line up
    idle(3, 1'b0, "R7 err line from bit 13");

    // R8: magic packet raises normal line
    step(32'h0000_4000, 1'b0, 1'b0, 32'h0, "R8 magic pulse");
    idle(3, 1'b0, "R8 norm line");

    // R3: clear only bit 13, zeros keep the rest
    step(32'h0, 1'b1, 1'b0, 32'h0000_2000, "R3 clear bit 13");
    idle(2, 1'b0, "R3 err line drops");

    // R4: set and clear collide on bit 9
    step(32'h0000_0200, 1'b1, 1'b0, 32'h0000_0200, "R4 collision");
    idle(2, 1'b0, "R4 bit 9 held, err line");

    // R9: bit 12 with mask bit 28 is outside both classes
    step(32'h0, 1'b1, 1'b0, 32'hFFFF_FFFF, "R3 clear all");
    idle(2, 1'b0, "R3 all cleared");
    step(32'h0000_1000, 1'b0, 1'b0, 32'h0, "R9 non-class event");
    idle(3, 1'b0, "R9 no line for bit 12");

    // R9: ECC event with enables cleared
    step(32'h0, 1'b1, 1'b1, 32'h0000_0000, "R9 mask cleared");
    step(32'h0000_6300, 1'b0, 1'b0, 32'h0, "R9 unmasked events");
    idle(3, 1'b0, "R9 lines stay low");

    // R5: every bit pulsed, gaps stay clear
    step(32'hFFFF_FFFF, 1'b0, 1'b0, 32'h0, "R5 all-ones pulse");
    idle(2, 1'b0, "R5 gap bits zero");

    // R10: repeated reads leave state intact
    idle(4, 1'b0, "R10 event read no side effect");
    idle(2, 1'b1, "R10 mask read");
    idle(2, 1'b0, "R10 event unchanged");

    // mixed traffic
    step(32'h0, 1'b1, 1'b1, 32'h7300_0000, "R6 mask reload");
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ev, wd;
      logic we, ad;
      ev = $urandom() & $urandom() & $urandom();
      wd = $urandom();
      we = ($urandom() % 4) == 0;
      ad = ($urandom() % 6) == 0;
      step(ev, we, ad, wd, "R7 R8 mixed traffic");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule